// File: doc/BRIEF.md
# Dual-Lane 8B/10B Decoder

This block sits on the receive side of a serial link, after word alignment. It turns 8B/10B code groups back into bytes. In narrow mode it takes one 10-bit code group per clock and returns one byte and a control flag. In wide mode it takes two code groups per clock and returns two bytes. The two decoders work in series inside the same cycle: the running disparity left by the low lane is the starting disparity of the high lane.

Each byte lane reports three flags of its own. The first marks a control character. The second marks a pattern that is in neither disparity column of the code table. The third marks a legal code group received in the wrong disparity column. The running disparity is kept in one register. It starts negative and is carried from the last active lane into the next clock cycle. All outputs are registered one cycle behind the input strobe.

Top module: `dual_8b10b_decoder`

## Requirements
- R1: Code group bits are numbered so that bit 0 is `a`, bit 5 is `i`, bit 6 is `f` and bit 9 is `j`. The decoded byte is HGFEDCBA, with EDCBA in bits [4:0] and HGF in bits [7:5]. A valid data code group yields its byte with control flag 0.
- R2: The twelve control code groups raise the lane's control flag and output the byte y·32+x. These are K.28.0 to K.28.7, plus K.23.7, K.27.7, K.29.7 and K.30.7 (for example K.28.5 gives 0xBC).
- R3: A 10-bit pattern that is in neither disparity column for any data or control value raises code error. In that case the byte is 0x00, the control flag is 0 and the disparity error is 0.
- R4: A legal code group that is absent from the column of the lane's starting running disparity raises disparity error. The lane still outputs its byte and control flag.
- R5: Running disparity is encoded 0 for negative and 1 for positive, and reset sets it to negative. After each code group it becomes positive if the group has more than five ones and negative if it has fewer than five; otherwise it is unchanged. This applies to errored groups as well.
- R6: In wide mode (`dbl_mode`=1), `code_in[9:0]` decodes to `data_out[7:0]` and `code_in[19:10]` decodes to `data_out[15:8]`, each lane with its own flags.
- R7: In wide mode, the high lane starts from the disparity left by the low lane in the same cycle. The high lane's ending disparity is carried to the next accepted word.
- R8: In narrow mode, `data_out[15:8]` and all lane-1 flags are 0, and only lane 0 updates the disparity.
- R9: `out_valid` equals `in_valid` delayed by one clock. While `in_valid` is 0, the data, the flags and the running disparity hold their values.
- R10: A synchronous reset clears `out_valid`, the data and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Code word strobe |
| dbl_mode | input | 1 | 1 = two code groups per clock, 0 = one |
| code_in | input | 20 | Code groups, lane 0 in [9:0] |
| out_valid | output | 1 | Decoded word valid |
| data_out | output | 16 | Decoded bytes, lane 0 in [7:0] |
| ctrl_out | output | 2 | Control character flag per lane |
| code_err | output | 2 | Illegal pattern flag per lane |
| disp_err | output | 2 | Wrong disparity column flag per lane |

## Verification
Random streams are built by encoding random bytes and control values with a tracked disparity, so every legal code group is reached in both columns. These are mixed with groups deliberately taken from the wrong column and with raw random 10-bit patterns. The mix separates a correct table lookup from a column check and from illegal-pattern detection. Directed cases cover the following:
- A comma character after reset.
- A positive-column group straight after reset, which exposes the reset disparity.
- A wide word whose low lane flips the disparity, which exposes whether the high lane is chained.
- Idle cycles with garbage on the input, which must change neither the outputs nor the carried disparity.

// File: rtl/dec8b10b_pkg.sv
package dec8b10b_pkg;

    localparam int CW    = 10;
    localparam int BW    = 8;
    localparam int NUM_K = 12;

    typedef struct packed {
        logic [BW-1:0] value;
        logic          is_ctrl;
        logic          bad_code;
        logic          bad_disp;
        logic          rd_end;
    } lane_res_t;

    // reverse a first-bit-leftmost literal into bit0 = first bit
    function automatic logic [5:0] rev6(input logic [5:0] s);
        logic [5:0] r;
        for (int i = 0; i < 6; i++) r[i] = s[5-i];
        return r;
    endfunction

    function automatic logic [3:0] rev4(input logic [3:0] s);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = s[3-i];
        return r;
    endfunction

    // 6-bit sub-block, negative column, literal written abcdei
    function automatic logic [5:0] six_neg(input logic [4:0] x);
        logic [5:0] t;
        case (x)
            5'd0:  t = 6'b100111;  5'd1:  t = 6'b011101;
            5'd2:  t = 6'b101101;  5'd3:  t = 6'b110001;
            5'd4:  t = 6'b110101;  5'd5:  t = 6'b101001;
            5'd6:  t = 6'b011001;  5'd7:  t = 6'b111000;
            5'd8:  t = 6'b111001;  5'd9:  t = 6'b100101;
            5'd10: t = 6'b010101;  5'd11: t = 6'b110100;
            5'd12: t = 6'b001101;  5'd13: t = 6'b101100;
            5'd14: t = 6'b011100;  5'd15: t = 6'b010111;
            5'd16: t = 6'b011011;  5'd17: t = 6'b100011;
            5'd18: t = 6'b010011;  5'd19: t = 6'b110010;
            5'd20: t = 6'b001011;  5'd21: t = 6'b101010;
            5'd22: t = 6'b011010;  5'd23: t = 6'b111010;
            5'd24: t = 6'b110011;  5'd25: t = 6'b100110;
            5'd26: t = 6'b010110;  5'd27: t = 6'b110110;
            5'd28: t = 6'b001110;  5'd29: t = 6'b101110;
            5'd30: t = 6'b011110;  default: t = 6'b101011;
        endcase
        return rev6(t);
    endfunction

    // 4-bit sub-block, negative column, literal written fghj
    function automatic logic [3:0] four_neg(input logic [2:0] y);
        logic [3:0] t;
        case (y)
            3'd0: t = 4'b1011;  3'd1: t = 4'b1001;
            3'd2: t = 4'b0101;  3'd3: t = 4'b1100;
            3'd4: t = 4'b1101;  3'd5: t = 4'b1010;
            3'd6: t = 4'b0110;  default: t = 4'b1110;
        endcase
        return rev4(t);
    endfunction

    function automatic logic [3:0] alt7_neg();
        return rev4(4'b0111);
    endfunction

    function automatic logic [5:0] six_col(input logic [4:0] x, input logic k28, input logic rd);
        logic [5:0] s;
        s = k28 ? rev6(6'b001111) : six_neg(x);
        if (rd && (($countones(s) != 3) || (!k28 && x == 5'd7))) s = ~s;
        return s;
    endfunction

    function automatic logic [3:0] four_pos(input logic [2:0] y, input logic alt);
        logic [3:0] s;
        s = alt ? alt7_neg() : four_neg(y);
        if (($countones(s) != 2) || (y == 3'd3)) s = ~s;
        return s;
    endfunction

    // full code group for a byte, control flag and starting disparity
    function automatic logic [CW-1:0] enc10(input logic [BW-1:0] v, input logic k, input logic rd);
        logic [4:0] x;
        logic [2:0] y;
        logic [5:0] s6;
        logic [3:0] n4, p4, s4;
        logic       rd1, alt;
        x   = v[4:0];
        y   = v[7:5];
        s6  = six_col(x, k && (x == 5'd28), rd);
        rd1 = ($countones(s6) == 3) ? rd : ($countones(s6) > 3);
        alt = (y == 3'd7) && (k || (!rd1 && (x == 5'd17 || x == 5'd18 || x == 5'd20))
                                || (rd1 && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
        n4  = alt ? alt7_neg() : four_neg(y);
        p4  = four_pos(y, alt);
        if (k) s4 = rd1 ? p4 : ~p4;
        else   s4 = rd1 ? p4 : n4;
        return {s4, s6};
    endfunction

    function automatic logic [BW-1:0] k_code(input int i);
        logic [BW-1:0] v;
        case (i)
            8:       v = {3'd7, 5'd23};
            9:       v = {3'd7, 5'd27};
            10:      v = {3'd7, 5'd29};
            11:      v = {3'd7, 5'd30};
            default: v = {3'(i), 5'd28};
        endcase
        return v;
    endfunction

    function automatic logic rd_after(input logic [CW-1:0] c, input logic rd);
        if ($countones(c) > CW/2) return 1'b1;
        if ($countones(c) < CW/2) return 1'b0;
        return rd;
    endfunction

endpackage

// File: rtl/dec8b10b_sb_lookup.sv
module dec8b10b_sb_lookup
    import dec8b10b_pkg::*;
(
    input  logic [CW-1:0] code,
    output logic [BW-1:0] cand
);
    // candidate data byte from independent sub-block matches
    always_comb begin
        cand = '0;
        for (int x = 0; x < 32; x++) begin
            if (code[5:0] == six_col(5'(x), 1'b0, 1'b0) ||
                code[5:0] == six_col(5'(x), 1'b0, 1'b1))
                cand[4:0] = 5'(x);
        end
        for (int y = 0; y < 8; y++) begin
            if (code[9:6] == four_neg(3'(y)) || code[9:6] == four_pos(3'(y), 1'b0))
                cand[7:5] = 3'(y);
        end
        if (code[9:6] == alt7_neg() || code[9:6] == four_pos(3'd7, 1'b1))
            cand[7:5] = 3'd7;
    end
endmodule

// File: rtl/dec8b10b_lane.sv
module dec8b10b_lane
    import dec8b10b_pkg::*;
(
    input  logic [CW-1:0] code,
    input  logic          rd_in,
    output lane_res_t     res
);
    logic [BW-1:0] cand;
    logic [BW-1:0] k_val;
    logic          d_neg, d_pos, k_neg, k_pos;

    dec8b10b_sb_lookup u_lookup (
        .code (code),
        .cand (cand)
    );

    always_comb begin
        // confirm the sub-block guess by re-encoding it in both columns
        d_neg = (enc10(cand, 1'b0, 1'b0) == code);
        d_pos = (enc10(cand, 1'b0, 1'b1) == code);
        k_neg = 1'b0;
        k_pos = 1'b0;
        k_val = '0;
        for (int i = 0; i < NUM_K; i++) begin
            if (enc10(k_code(i), 1'b1, 1'b0) == code) begin
                k_neg = 1'b1;
                k_val = k_code(i);
            end
            if (enc10(k_code(i), 1'b1, 1'b1) == code) begin
                k_pos = 1'b1;
                k_val = k_code(i);
            end
        end

        res        = '0;
        res.rd_end = rd_after(code, rd_in);
        if (k_neg || k_pos) begin
            res.value    = k_val;
            res.is_ctrl  = 1'b1;
            res.bad_disp = rd_in ? !k_pos : !k_neg;
        end else if (d_neg || d_pos) begin
            res.value    = cand;
            res.bad_disp = rd_in ? !d_pos : !d_neg;
        end else begin
            res.bad_code = 1'b1;
        end
    end
endmodule

// File: rtl/dual_8b10b_decoder.sv
module dual_8b10b_decoder
    import dec8b10b_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    dbl_mode,
    input  logic [NUM_LANES*CW-1:0] code_in,
    output logic                    out_valid,
    output logic [NUM_LANES*BW-1:0] data_out,
    output logic [NUM_LANES-1:0]    ctrl_out,
    output logic [NUM_LANES-1:0]    code_err,
    output logic [NUM_LANES-1:0]    disp_err
);
    localparam int NL = NUM_LANES;

    typedef struct packed {
        logic             vld;
        logic             rd;
        logic [NL*BW-1:0] data;
        logic [NL-1:0]    ctrl;
        logic [NL-1:0]    cerr;
        logic [NL-1:0]    derr;
    } state_t;

    state_t    st_q, st_d;
    lane_res_t lane_res [NL];
    logic      lane_rd  [NL];

    // lanes in series: each starts from the previous lane's ending disparity
    for (genvar g = 0; g < NL; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign lane_rd[g] = st_q.rd;
        end else begin : g_chain
            assign lane_rd[g] = lane_res[g-1].rd_end;
        end
        dec8b10b_lane u_lane (
            .code  (code_in[g*CW +: CW]),
            .rd_in (lane_rd[g]),
            .res   (lane_res[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.rd = dbl_mode ? lane_res[NL-1].rd_end : lane_res[0].rd_end;
            for (int i = 0; i < NL; i++) begin
                if (i == 0 || dbl_mode) begin
                    st_d.data[i*BW +: BW] = lane_res[i].value;
                    st_d.ctrl[i]          = lane_res[i].is_ctrl;
                    st_d.cerr[i]          = lane_res[i].bad_code;
                    st_d.derr[i]          = lane_res[i].bad_disp;
                end else begin
                    st_d.data[i*BW +: BW] = '0;
                    st_d.ctrl[i]          = 1'b0;
                    st_d.cerr[i]          = 1'b0;
                    st_d.derr[i]          = 1'b0;
                end
            end
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign data_out  = st_q.data;
    assign ctrl_out  = st_q.ctrl;
    assign code_err  = st_q.cerr;
    assign disp_err  = st_q.derr;

endmodule

// File: rtl/dual_8b10b_decoder_chk.sv
module dual_8b10b_decoder_chk #(
    parameter int NUM_LANES = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic                   dbl_mode,
    input logic                   out_valid,
    input logic [NUM_LANES*8-1:0] data_out,
    input logic [NUM_LANES-1:0]   ctrl_out,
    input logic [NUM_LANES-1:0]   code_err,
    input logic [NUM_LANES-1:0]   disp_err
);
    // R9: strobe goes through with one clock of delay
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9: idle cycles leave the outputs alone
    a_r9_hold_outputs: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(data_out) && $stable(ctrl_out) && $stable(code_err) && $stable(disp_err)));
    // R8: narrow mode keeps upper lanes quiet
    a_r8_upper_quiet: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dbl_mode) |=> (data_out[NUM_LANES*8-1:8] == '0 && ctrl_out[NUM_LANES-1:1] == '0
                                     && code_err[NUM_LANES-1:1] == '0 && disp_err[NUM_LANES-1:1] == '0));
    // R3: an illegal pattern carries no other flag and a zero byte
    a_r3_err_clean: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((code_err & (ctrl_out | disp_err)) == '0));
    a_r3_zero_byte: assert property (@(posedge clk) disable iff (rst)
        (out_valid && code_err[0]) |-> (data_out[7:0] == 8'h00));
    // R2: control bytes are K.28.y or K.x.7
    a_r2_ctrl_values: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ctrl_out[0]) |-> (data_out[4:0] == 5'd28 || data_out[7:5] == 3'd7));
endmodule

bind dual_8b10b_decoder dual_8b10b_decoder_chk #(.NUM_LANES(NUM_LANES)) u_chk (.*);

// File: tb/tb_dual_8b10b_decoder.sv
module tb_dual_8b10b_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        dbl_mode = 1'b0;
    logic [19:0] code_in = '0;
    logic        out_valid;
    logic [15:0] data_out;
    logic [1:0]  ctrl_out, code_err, disp_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // expected state
    logic        e_vld = 1'b0, e_dbl = 1'b0, m_rd = 1'b0;
    logic [15:0] e_data = '0;
    logic [1:0]  e_ctrl = '0, e_cerr = '0, e_derr = '0;

    always #10 clk = ~clk;   // 50 MHz

    dual_8b10b_decoder #(.NUM_LANES(2)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .dbl_mode(dbl_mode),
        .code_in(code_in), .out_valid(out_valid), .data_out(data_out),
        .ctrl_out(ctrl_out), .code_err(code_err), .disp_err(disp_err)
    );

    // ---------------- reference encoder (bit 0 = a) ----------------
    function automatic logic [5:0] t6(input int x);
        logic [5:0] w [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
                               6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
                               6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011,
                               6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
                               6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
                               6'b011110, 6'b101011};
        logic [5:0] r;
        for (int i = 0; i < 6; i++) r[i] = w[x][5-i];
        return r;
    endfunction

    function automatic logic [3:0] t4(input int y, input bit alt);
        logic [3:0] w [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
        logic [3:0] s, r;
        s = alt ? 4'b0111 : w[y];
        for (int i = 0; i < 4; i++) r[i] = s[3-i];
        return r;
    endfunction

    function automatic logic [9:0] benc(input logic [7:0] v, input bit k, input bit rd);
        int x, y;
        logic [5:0] a6;
        logic [3:0] n4, p4, b4;
        bit r1, alt;
        x  = int'(v[4:0]);
        y  = int'(v[7:5]);
        a6 = (k && x == 28) ? 6'b111100 : t6(x);
        if (rd && ($countones(a6) != 3 || (x == 7 && !(k && x == 28)))) a6 = ~a6;
        r1  = ($countones(a6) == 3) ? rd : ($countones(a6) > 3);
        alt = (y == 7) && (k || (!r1 && (x == 17 || x == 18 || x == 20)) || (r1 && (x == 11 || x == 13 || x == 14)));
        n4  = t4(y, alt);
        p4  = ($countones(n4) != 2 || y == 3) ? ~n4 : n4;
        if (k) b4 = r1 ? p4 : ~p4;
        else   b4 = r1 ? p4 : n4;
        return {b4, a6};
    endfunction

    function automatic bit is_k(input logic [7:0] v);
        return (v[4:0] == 5'd28) || (v[7:5] == 3'd7 &&
               (v[4:0] == 5'd23 || v[4:0] == 5'd27 || v[4:0] == 5'd29 || v[4:0] == 5'd30));
    endfunction

    function automatic bit rd_next(input logic [9:0] c, input bit rd);
        if ($countones(c) > 5) return 1'b1;
        if ($countones(c) < 5) return 1'b0;
        return rd;
    endfunction

    // reference decode by exhaustive search of the code table
    task automatic ref_lane(input logic [9:0] c, input bit rd, output logic [7:0] b,
                            output bit k, output bit ce, output bit de);
        bit found = 0, col = 0;
        b = '0; k = 0;
        for (int kk = 0; kk < 2; kk++)
            for (int v = 0; v < 256; v++) begin
                if (kk == 1 && !is_k(8'(v))) continue;
                for (int r = 0; r < 2; r++)
                    if (benc(8'(v), kk[0], r[0]) == c) begin
                        found = 1; b = 8'(v); k = kk[0];
                        if (r[0] == rd) col = 1;
                    end
            end
        ce = !found;
        de = found && !col;
        if (!found) begin b = '0; k = 0; end
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R9 out_valid", 16'(out_valid), 16'(e_vld));
        chk("R1 lane0 data", 16'(data_out[7:0]), 16'(e_data[7:0]));
        chk("R2 lane0 ctrl", 16'(ctrl_out[0]), 16'(e_ctrl[0]));
        chk("R3 lane0 code_err", 16'(code_err[0]), 16'(e_cerr[0]));
        chk("R4 lane0 disp_err", 16'(disp_err[0]), 16'(e_derr[0]));
        if (e_dbl) begin
            chk("R6 lane1 data", 16'(data_out[15:8]), 16'(e_data[15:8]));
            chk("R2 lane1 ctrl", 16'(ctrl_out[1]), 16'(e_ctrl[1]));
            chk("R3 lane1 code_err", 16'(code_err[1]), 16'(e_cerr[1]));
            chk("R7 lane1 disp_err", 16'(disp_err[1]), 16'(e_derr[1]));
        end else begin
            chk("R8 lane1 quiet", {data_out[15:8], 2'b00, ctrl_out[1], code_err[1], disp_err[1]}, 16'h0);
        end
    endtask

    // one cycle: drive at a falling edge, compare at the next falling edge
    task automatic step(input bit vld, input bit dbl, input logic [19:0] code);
        logic [7:0] b; bit k, ce, de, r0;
        in_valid = vld; dbl_mode = dbl; code_in = code;
        if (vld) begin
            e_vld = 1; e_dbl = dbl;
            ref_lane(code[9:0], m_rd, b, k, ce, de);
            e_data[7:0] = b; e_ctrl[0] = k; e_cerr[0] = ce; e_derr[0] = de;
            r0 = rd_next(code[9:0], m_rd);
            if (dbl) begin
                ref_lane(code[19:10], r0, b, k, ce, de);
                e_data[15:8] = b; e_ctrl[1] = k; e_cerr[1] = ce; e_derr[1] = de;
                m_rd = rd_next(code[19:10], r0);
            end else begin
                e_data[15:8] = '0; e_ctrl[1] = 0; e_cerr[1] = 0; e_derr[1] = 0;
                m_rd = r0;
            end
        end else begin
            e_vld = 0;
        end
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst = 1; in_valid = 0;
        @(posedge clk);
        @(negedge clk);
        chk("R10 reset valid", 16'(out_valid), 16'h0);
        chk("R10 reset data", data_out, 16'h0);
        chk("R10 reset flags", {10'h0, ctrl_out, code_err, disp_err}, 16'h0);
        e_vld = 0; e_dbl = 0; m_rd = 0; e_data = '0; e_ctrl = '0; e_cerr = '0; e_derr = '0;
        rst = 0;
    endtask

    function automatic logic [9:0] gen(input bit rd);
        int r = int'($urandom % 100);
        logic [7:0] v = 8'($urandom);
        bit k = 0;
        if (r < 12) begin
            int i = int'($urandom % 12);
            v = (i < 8) ? {3'(i), 5'd28} : {3'd7, (i == 8) ? 5'd23 : (i == 9) ? 5'd27 : (i == 10) ? 5'd29 : 5'd30};
            k = 1;
        end
        if (r < 70 && r >= 12 || r < 12 && ($urandom % 4) != 0) return benc(v, k, rd);
        if (r < 85) return benc(v, k, !rd);
        return 10'($urandom);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [9:0] c0;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();                                   // R10

        step(1, 0, {10'h3FF, benc(8'hBC, 1, 0)});     // R2 comma from negative
        chk("R2 K.28.5 byte", {data_out[7:0], 7'h0, ctrl_out[0]}, {8'hBC, 8'h01});

        do_reset();
        step(1, 0, {10'h0, benc(8'h00, 0, 1)});       // R5 reset disparity is negative
        chk("R5 positive column after reset", 16'(disp_err[0]), 16'h1);

        step(1, 0, {10'h0, 10'h000});                 // R3 all zeros
        chk("R3 zero pattern", {6'h0, data_out[7:0], code_err[0], ctrl_out[0]}, 16'h0002);
        step(1, 0, {10'h0, 10'h3FF});                 // R3 all ones

        do_reset();
        // R7: lane 0 comma leaves positive, lane 1 legal only in positive column
        step(1, 1, {benc(8'h00, 0, 1), benc(8'hBC, 1, 0)});
        chk("R7 chained lane no error", 16'(disp_err), 16'h0);
        step(1, 1, {benc(8'h00, 0, 1), benc(8'hBC, 1, 0)});

        // R9: idle cycles with garbage must not disturb outputs or disparity
        for (int i = 0; i < 3; i++) step(0, ($urandom % 2) == 1, 20'($urandom));
        step(1, 0, {10'h0, benc(8'h00, 0, m_rd)});
        chk("R9 disparity held across idle", 16'(disp_err[0]), 16'h0);

        for (int n = 0; n < 4000; n++) begin
            bit vld = ($urandom % 100) < 85;
            bit dbl = ($urandom % 2) == 1;
            c0 = gen(m_rd);
            step(vld, dbl, {gen(rd_next(c0, m_rd)), c0});
            if (n == 2000) do_reset();                // R10 mid-run
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule